// File: doc/BRIEF.md
# Interrupt Daisy-Chain Priority Controller

This block arbitrates among six interrupt sources of one peripheral. The peripheral also takes part in a board-level priority chain, with a chain-enable input and a chain-enable output. The six sources are receive, transmit and line-status events for each of two serial channels. Inside the block they form their own ripple chain, which continues the external chain. Each source has three bits:

- a pending level, taken from the channel logic;
- an enable mask bit, taken from configuration;
- an in-service bit, held inside this block.

The block requests service on an active-low interrupt output. The host signals an acknowledge cycle by driving the acknowledge strobe low, and the block samples that strobe on each rising clock edge. After the chain has settled, the host lowers the read strobe. The block then records the highest-priority source that is enabled and pending, and that is not blocked by an in-service source. It sets that source's in-service bit and places an 8-bit vector on the data bus. The vector is a programmed base byte. A 3-bit source code can optionally replace part of it, and a suppress flag can keep the bus undriven.

A command pulse retires the highest-priority in-service bit, which reopens the chain for lower sources. A master enable gates the whole chain. Clearing it has the same effect as a low chain input.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset, `int_n` is high, `vec_oe` is low, `vec_out` is zero, and no in-service bit is set, so `ieo` equals `iei` while `master_en` is high.
- R2: Outside an acknowledge cycle, `ieo` is high exactly when `iei` and `master_en` are high and no source is in service. Pending bits do not affect `ieo` outside an acknowledge cycle.
- R3: In an acknowledge cycle, a source that is both pending and enabled pulls the chain low for itself and all lower sources. A source that is pending but masked passes the chain unchanged.
- R4: While `master_en` is low, `ieo` is low and `int_n` is high one cycle later, whatever the sources do.
- R5: `int_n` goes low one clock after these conditions all hold for some source, and high one clock after they stop holding: the source is pending and enabled, it is not in service, no higher-priority source is in service, `iei` is high and `master_en` is high.
- R6: An acknowledge cycle exists only in cycles following a rising edge at which `ack_n` was low. A low `rd_n` outside such a cycle drives no vector and sets no in-service bit.
- R7: Priority is fixed by source index, and index 0 is the highest: 0 A-receive, 1 A-transmit, 2 A-status, 3 B-receive, 4 B-transmit, 5 B-status. The acknowledged source is the lowest-index source that is pending and enabled and has a high chain input.
- R8: The first rising edge with an acknowledge cycle and `rd_n` low captures the winning source and sets its in-service bit. From the next cycle, `vec_oe` is high for as long as `rd_n` stays low and the acknowledge cycle lasts.
- R9: With `code_en` low the vector equals `base_vec`. With `code_en` high, bits [3:1] are replaced by the winning source index, and the other bits come from `base_vec`.
- R10: With `no_vec` high, `vec_oe` stays low during the read, but the in-service bit of the winning source is still set.
- R11: A one-cycle pulse on `clr_top_ius` clears only the highest-priority in-service bit that is set.
- R12: A read in an acknowledge cycle with no winner (for example, `iei` low) drives no vector and sets no in-service bit.
- R13: An in-service source blocks lower-priority sources from both the request and the acknowledge. It does not block higher-priority sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; all sampling is on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pend | input | 6 | Pending level per source, index 0 highest |
| src_en | input | 6 | Enable mask per source |
| master_en | input | 1 | Master enable for the whole chain |
| base_vec | input | 8 | Programmed base vector |
| code_en | input | 1 | Replace vector bits [3:1] with the source index |
| no_vec | input | 1 | Suppress driving the vector |
| clr_top_ius | input | 1 | Pulse: retire highest-priority in-service bit |
| iei | input | 1 | Chain enable in from the higher-priority device |
| ack_n | input | 1 | Acknowledge strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| ieo | output | 1 | Chain enable out to the lower-priority device |
| int_n | output | 1 | Interrupt request, active low, registered |
| vec_out | output | 8 | Vector data, zero when not driven |
| vec_oe | output | 1 | Vector output enable |

## Verification
The checker tests on every cycle the rules that hold without history:
- a low `iei` forces `ieo` low;
- a low `iei` or a cleared master enable keeps `int_n` high on the next cycle;
- the vector is driven only while `rd_n` is low, in an acknowledge cycle, and with `no_vec` clear;
- an uncoded vector equals the base, and a coded vector carries a legal source index.

Only the directed scenarios can show which source wins and that its in-service bit is set, because in-service state appears only through later effects. Those effects are the chain output, the request, and the next acknowledge. The scenarios also cover retiring bits in priority order and the blocking that in-service sources impose on lower sources but not on higher ones.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    localparam int unsigned SRC_COUNT = 6;
    localparam int unsigned VEC_BITS  = 8;
    localparam int unsigned CODE_POS  = 1;

    // Source positions, highest priority first
    localparam int unsigned SRC_A_RX  = 0;
    localparam int unsigned SRC_A_TX  = 1;
    localparam int unsigned SRC_A_ST  = 2;
    localparam int unsigned SRC_B_RX  = 3;
    localparam int unsigned SRC_B_TX  = 4;
    localparam int unsigned SRC_B_ST  = 5;

endpackage

// File: rtl/irq_prio_chain.sv
// Ripple chain over the sources: acknowledge chain, request chain, winner.
module irq_prio_chain #(
    parameter int unsigned NUM_SRC = 6
) (
    input  logic               chain_in,
    input  logic               ack_cyc,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] ius,
    output logic               chain_out,
    output logic [NUM_SRC-1:0] winner,
    output logic               req_any
);
    logic [NUM_SRC:0]   ack_link;
    logic [NUM_SRC:0]   req_link;
    logic [NUM_SRC-1:0] want;

    assign ack_link[0] = chain_in;
    assign req_link[0] = chain_in;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_stage
        logic armed;
        assign armed         = pend[i] & en[i];
        // acknowledge ripple: in-service always blocks, armed blocks only in ack
        assign ack_link[i+1] = ack_link[i] & ~ius[i] & ~(ack_cyc & armed);
        assign winner[i]     = ack_cyc & ack_link[i] & armed & ~ius[i];
        // request ripple: only in-service sources block
        assign req_link[i+1] = req_link[i] & ~ius[i];
        assign want[i]       = req_link[i] & armed & ~ius[i];
    end

    assign chain_out = ack_link[NUM_SRC];
    assign req_any   = |want;

endmodule

// File: rtl/irq_first_set.sv
// Lowest-index set bit: one-hot mask, binary index and presence flag.
module irq_first_set #(
    parameter int unsigned WIDTH = 6,
    localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] bits,
    output logic [WIDTH-1:0] first,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        first = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (bits[i]) begin
                first = '0;
                first[i] = 1'b1;
                idx   = IDX_W'(i);
                any   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_vec_fmt.sv
// Builds the vector byte from the base and an optional source code field.
module irq_vec_fmt #(
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned CODE_W   = 3,
    parameter int unsigned CODE_LSB = 1
) (
    input  logic [VEC_W-1:0]  base,
    input  logic              code_en,
    input  logic [CODE_W-1:0] code,
    output logic [VEC_W-1:0]  vec
);
    localparam logic [VEC_W-1:0] FIELD_MASK =
        VEC_W'(((1 << CODE_W) - 1) << CODE_LSB);

    logic [VEC_W-1:0] code_shifted;
    assign code_shifted = VEC_W'(code) << CODE_LSB;

    always_comb begin
        if (code_en) begin
            vec = (base & ~FIELD_MASK) | (code_shifted & FIELD_MASK);
        end else begin
            vec = base;
        end
    end

endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
    import irq_chain_pkg::*;
#(
    parameter int unsigned NUM_SRC  = SRC_COUNT,
    parameter int unsigned VEC_W    = VEC_BITS,
    parameter int unsigned CODE_LSB = CODE_POS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pend,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               master_en,
    input  logic [VEC_W-1:0]   base_vec,
    input  logic               code_en,
    input  logic               no_vec,
    input  logic               clr_top_ius,
    input  logic               iei,
    input  logic               ack_n,
    input  logic               rd_n,
    output logic               ieo,
    output logic               int_n,
    output logic [VEC_W-1:0]   vec_out,
    output logic               vec_oe
);
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic               ack_cyc;
        logic               rd_seen;
        logic               hit;
        logic [IDX_W-1:0]   src_idx;
        logic [NUM_SRC-1:0] ius;
        logic               int_n;
    } state_t;

    state_t st_q, st_d;

    logic               chain_in;
    logic [NUM_SRC-1:0] winner;
    logic               req_any;
    logic               chain_out;
    logic [NUM_SRC-1:0] win_first;
    logic [IDX_W-1:0]   win_idx;
    logic               win_any;
    logic [NUM_SRC-1:0] top_ius;
    logic [IDX_W-1:0]   top_idx;
    logic               top_any;
    logic [VEC_W-1:0]   vec_word;
    logic               capture;

    assign chain_in = iei & master_en;

    irq_prio_chain #(.NUM_SRC(NUM_SRC)) i_chain (
        .chain_in (chain_in),
        .ack_cyc  (st_q.ack_cyc),
        .pend     (src_pend),
        .en       (src_en),
        .ius      (st_q.ius),
        .chain_out(chain_out),
        .winner   (winner),
        .req_any  (req_any)
    );

    irq_first_set #(.WIDTH(NUM_SRC)) i_win_enc (
        .bits (winner),
        .first(win_first),
        .idx  (win_idx),
        .any  (win_any)
    );

    irq_first_set #(.WIDTH(NUM_SRC)) i_top_ius (
        .bits (st_q.ius),
        .first(top_ius),
        .idx  (top_idx),
        .any  (top_any)
    );

    irq_vec_fmt #(.VEC_W(VEC_W), .CODE_W(IDX_W), .CODE_LSB(CODE_LSB)) i_fmt (
        .base   (base_vec),
        .code_en(code_en),
        .code   (st_q.src_idx),
        .vec    (vec_word)
    );

    // First read edge inside an acknowledge cycle
    assign capture = st_q.ack_cyc & ~rd_n & ~st_q.rd_seen;

    always_comb begin
        st_d         = st_q;
        st_d.ack_cyc = ~ack_n;
        st_d.rd_seen = st_q.ack_cyc & ~rd_n;

        if (capture) begin
            st_d.hit     = win_any;
            st_d.src_idx = win_idx;
        end else if (!st_q.ack_cyc) begin
            st_d.hit     = 1'b0;
            st_d.src_idx = '0;
        end

        if (clr_top_ius && top_any) begin
            st_d.ius = st_d.ius & ~top_ius;
        end
        if (capture && win_any) begin
            st_d.ius = st_d.ius | win_first;
        end

        st_d.int_n = ~req_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.int_n   <= 1'b1;
        end else begin
            st_q         <= st_d;
        end
    end

    assign ieo     = chain_out;
    assign int_n   = st_q.int_n;
    assign vec_oe  = st_q.rd_seen & st_q.ack_cyc & st_q.hit & ~rd_n & ~no_vec;
    assign vec_out = vec_oe ? vec_word : '0;

    // top_idx kept for debug visibility of the retire path
    logic unused_ok;
    assign unused_ok = ^top_idx;

endmodule

// File: rtl/irq_chain_checker.sv
module irq_chain_checker #(
    parameter int unsigned NUM_SRC  = 6,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned CODE_LSB = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             master_en,
    input logic [VEC_W-1:0] base_vec,
    input logic             code_en,
    input logic             no_vec,
    input logic             iei,
    input logic             ack_n,
    input logic             rd_n,
    input logic             ieo,
    input logic             int_n,
    input logic [VEC_W-1:0] vec_out,
    input logic             vec_oe
);
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    p_ieo_follows_low_iei_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !iei |-> !ieo);

    p_master_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> int_n);

    p_iei_low_no_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !iei |=> int_n);

    p_vector_needs_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> $past(!ack_n));

    p_vector_needs_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> !rd_n);

    p_plain_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe && !code_en) |-> (vec_out == base_vec));

    p_code_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe && code_en) |-> (int'(vec_out[CODE_LSB +: IDX_W]) < NUM_SRC));

    p_suppressed_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> !no_vec);

    p_idle_bus_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe |-> (vec_out == '0));

endmodule

bind irq_chain_ctrl irq_chain_checker #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W),
    .CODE_LSB(CODE_LSB)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .master_en(master_en),
    .base_vec (base_vec),
    .code_en  (code_en),
    .no_vec   (no_vec),
    .iei      (iei),
    .ack_n    (ack_n),
    .rd_n     (rd_n),
    .ieo      (ieo),
    .int_n    (int_n),
    .vec_out  (vec_out),
    .vec_oe   (vec_oe)
);

// File: tb/test_irq_chain_ctrl.sv
module test_irq_chain_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  N          = 6;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] src_pend;
    logic [N-1:0] src_en;
    logic         master_en;
    logic [7:0]   base_vec;
    logic         code_en;
    logic         no_vec;
    logic         clr_top_ius;
    logic         iei;
    logic         ack_n;
    logic         rd_n;
    logic         ieo;
    logic         int_n;
    logic [7:0]   vec_out;
    logic         vec_oe;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_chain_ctrl i_irq_chain_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_pend   (src_pend),
        .src_en     (src_en),
        .master_en  (master_en),
        .base_vec   (base_vec),
        .code_en    (code_en),
        .no_vec     (no_vec),
        .clr_top_ius(clr_top_ius),
        .iei        (iei),
        .ack_n      (ack_n),
        .rd_n       (rd_n),
        .ieo        (ieo),
        .int_n      (int_n),
        .vec_out    (vec_out),
        .vec_oe     (vec_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n       = 1'b0;
        src_pend    = '0;
        src_en      = '1;
        master_en   = 1'b1;
        base_vec    = 8'hA0;
        code_en     = 1'b0;
        no_vec      = 1'b0;
        clr_top_ius = 1'b0;
        iei         = 1'b1;
        ack_n       = 1'b1;
        rd_n        = 1'b1;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    // Full acknowledge: ack low, settle, read, sample, release.
    task automatic ack_read(output logic oe, output logic [7:0] v, output logic ieo_mid);
        ack_n = 1'b0;
        tick(1);
        ieo_mid = ieo;
        tick(1);
        rd_n = 1'b0;
        tick(1);
        oe = vec_oe;
        v  = vec_out;
        rd_n  = 1'b1;
        ack_n = 1'b1;
        tick(2);
    endtask

    task automatic pulse_clear();
        clr_top_ius = 1'b1;
        tick(1);
        clr_top_ius = 1'b0;
        tick(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 int_n", int_n, 1);
        chk("R1 vec_oe", vec_oe, 0);
        chk("R1 vec_out", vec_out, 0);
        chk("R1 ieo", ieo, 1);
    endtask

    task automatic t_passthru();
        do_reset();
        src_pend = 6'b010101;
        tick(1);
        chk("R2 pend ignored outside ack", ieo, 1);
        iei = 1'b0;
        tick(1);
        chk("R2 iei low", ieo, 0);
    endtask

    task automatic t_ack_chain();
        logic oe; logic [7:0] v; logic mid;
        do_reset();
        src_pend = 6'b000010;
        src_en   = 6'b111101;
        ack_read(oe, v, mid);
        chk("R3 masked passes", mid, 1);
        chk("R3 masked no vector", oe, 0);
        src_en = '1;
        ack_read(oe, v, mid);
        chk("R3 armed source blocks", mid, 0);
    endtask

    task automatic t_master();
        do_reset();
        src_pend  = 6'b100000;
        tick(1);
        chk("R5 request", int_n, 0);
        master_en = 1'b0;
        tick(1);
        chk("R4 ieo", ieo, 0);
        chk("R4 int_n", int_n, 1);
    endtask

    task automatic t_request();
        do_reset();
        src_pend = 6'b000100;
        tick(1);
        chk("R5 int low", int_n, 0);
        src_en = 6'b111011;
        tick(1);
        chk("R5 masked", int_n, 1);
        src_en = '1;
        iei    = 1'b0;
        tick(1);
        chk("R5 iei low", int_n, 1);
    endtask

    task automatic t_no_ack();
        logic oe; logic [7:0] v; logic mid;
        do_reset();
        src_pend = 6'b000001;
        rd_n = 1'b0;
        tick(2);
        chk("R6 read without ack", vec_oe, 0);
        rd_n = 1'b1;
        tick(1);
        chk("R6 no in-service set", ieo, 1);
        ack_read(oe, v, mid);
        chk("R6 ack read drives", oe, 1);
    endtask

    task automatic t_priority();
        logic oe; logic [7:0] v; logic mid;
        do_reset();
        code_en  = 1'b1;
        src_pend = 6'b010010;
        ack_read(oe, v, mid);
        chk("R8 oe", oe, 1);
        chk("R7 winner is source 1", v, 8'hA2);
        chk("R8 ius blocks chain", ieo, 0);
        ack_read(oe, v, mid);
        chk("R13 lower blocked in ack", oe, 0);
        chk("R13 lower blocked in request", int_n, 1);
        do_reset();
        code_en  = 1'b1;
        src_pend = 6'b010010;
        src_en   = 6'b111101;
        ack_read(oe, v, mid);
        chk("R7 masked higher skipped", v, 8'hA8);
    endtask

    task automatic t_format();
        logic oe; logic [7:0] v; logic mid;
        do_reset();
        base_vec = 8'hAF;
        src_pend = 6'b000100;
        ack_read(oe, v, mid);
        chk("R9 plain base", v, 8'hAF);
        do_reset();
        base_vec = 8'hAF;
        code_en  = 1'b1;
        src_pend = 6'b000100;
        ack_read(oe, v, mid);
        chk("R9 coded idx2", v, 8'hA5);
        do_reset();
        base_vec = 8'h61;
        code_en  = 1'b1;
        src_pend = 6'b100000;
        ack_read(oe, v, mid);
        chk("R9 coded idx5", v, 8'h6B);
    endtask

    task automatic t_novec();
        logic oe; logic [7:0] v; logic mid;
        do_reset();
        no_vec   = 1'b1;
        src_pend = 6'b000001;
        ack_read(oe, v, mid);
        chk("R10 bus idle", oe, 0);
        chk("R10 ius still set", ieo, 0);
        chk("R10 request withdrawn", int_n, 1);
    endtask

    task automatic t_clear();
        logic oe; logic [7:0] v; logic mid;
        do_reset();
        src_pend = 6'b001000;
        ack_read(oe, v, mid);
        src_pend = 6'b001001;
        tick(1);
        chk("R13 higher not blocked", int_n, 0);
        ack_read(oe, v, mid);
        chk("R13 higher acknowledged", oe, 1);
        src_pend = 6'b001010;
        tick(1);
        chk("R13 source 1 blocked by ius0", int_n, 1);
        pulse_clear();
        chk("R11 top cleared, source 1 requests", int_n, 0);
        chk("R11 lower ius kept", ieo, 0);
        src_pend = 6'b001000;
        tick(1);
        chk("R11 own ius blocks source 3", int_n, 1);
        pulse_clear();
        chk("R11 all cleared", ieo, 1);
        chk("R11 source 3 requests again", int_n, 0);
    endtask

    task automatic t_no_winner();
        logic oe; logic [7:0] v; logic mid;
        do_reset();
        src_pend = 6'b000001;
        iei      = 1'b0;
        ack_read(oe, v, mid);
        chk("R12 no drive", oe, 0);
        iei = 1'b1;
        tick(2);
        chk("R12 no ius", ieo, 1);
        chk("R12 request live", int_n, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_passthru();
        t_ack_chain();
        t_master();
        t_request();
        t_no_ack();
        t_priority();
        t_format();
        t_novec();
        t_clear();
        t_no_winner();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

endmodule